// File: doc/BRIEF.md
# Transmit I/Q Quadrature and DC Corrector

This block sits as the last digital stage before the I and Q transmit converters. It receives a paired I/Q sample stream and repairs two faults of the analogue path that follows. First it mixes a small signed share of each channel into the other, which cancels the phase error of a quadrature modulator whose two carriers are not exactly 90 degrees apart. Then it adds a separate DC term to each channel to cancel offsets of the analogue stages. Both steps clip to the sample range rather than wrapping.

Four settings (two mixing coefficients, two DC terms) are written into a staging bank through a simple write strobe. A separate apply strobe arms a transfer of the whole staging bank into the working bank, and that transfer happens only at the next accepted sample, so every sample is corrected with one coherent set of settings. Both channels of a pair leave together, two clock cycles after they enter, with a valid flag that travels alongside.

Top module: `iqc_corrector`

## Requirements
- R1: For each accepted pair, the phase stage forms I + floor(Q*ci / 2^(CW+2)) and Q + floor(I*cq / 2^(CW+2)), where ci and cq are CW-bit two's complement coefficients and both terms use the uncorrected inputs; code -2^(CW-1) therefore means exactly -1/8.
- R2: Each phase-stage sum is clipped to [-2^(DW-1), 2^(DW-1)-1] before the DC term is added, so the DC term acts on the clipped value.
- R3: The DC stage adds a DW-bit two's complement offset (any value across the full negative-to-positive range) per channel and clips the result to the same range.
- R4: out_valid is in_valid delayed by exactly two clock cycles, and out_i and out_q of one pair update on the same edge.
- R5: While out_valid is low, out_i and out_q keep their previous values.
- R6: A write with cfg_wr high stores cfg_data into the staging slot picked by cfg_sel (0: ci, coupling Q into I; 1: cq, coupling I into Q; 2: I offset; 3: Q offset; coefficients take the low CW bits); staging alone never changes the outputs.
- R7: cfg_apply arms a transfer; the working bank loads the staging bank on the first later edge where in_valid is high (that edge's sample still uses the old bank, and a staging write on that same edge is not included); the working bank changes on no other edge.
- R8: After synchronous reset, out_valid, out_i and out_q are zero and all settings are zero, so samples pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair present this cycle |
| in_i | input | DW | Input I sample, signed |
| in_q | input | DW | Input Q sample, signed |
| cfg_wr | input | 1 | Staging write strobe |
| cfg_sel | input | 2 | Staging slot select |
| cfg_data | input | DW | Staging write data |
| cfg_apply | input | 1 | Arm transfer of staging to working bank |
| out_valid | output | 1 | Output pair present |
| out_i | output | DW | Corrected I sample, signed |
| out_q | output | DW | Corrected Q sample, signed |

## Verification
Two functions meet in one cycle in two places: a settings transfer lands on the same edge that accepts a sample, and the phase stage clips on the same sample where a DC term pulls the value back inside range. The bench provokes the first by arming a transfer while in_valid is low and then presenting a sample together with a fresh staging write, and the second by driving full-scale inputs with the largest coefficient and an opposing offset. A behavioural model with its own bank, arm flag and two-entry delay line predicts every output each clock, so a wrong choice of bank or a missing intermediate clip shows up as a value mismatch on the exact sample concerned.

// File: rtl/iqc_pkg.sv
package iqc_pkg;

    localparam int SAMPLE_W_DEF = 16;
    localparam int COEF_W_DEF   = 12;
    localparam int LANES        = 2;

    typedef enum logic [1:0] {
        SLOT_COEF_I = 2'd0,
        SLOT_COEF_Q = 2'd1,
        SLOT_OFS_I  = 2'd2,
        SLOT_OFS_Q  = 2'd3
    } cfg_slot_e;

    // Clamp a wide signed value into a w-bit two's complement range.
    function automatic longint clamp_to(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/iqc_regbank.sv
module iqc_regbank
    import iqc_pkg::*;
#(
    parameter int DW = SAMPLE_W_DEF,
    parameter int CW = COEF_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_sel,
    input  logic [DW-1:0]        cfg_data,
    input  logic                 cfg_apply,
    output logic signed [CW-1:0] act_coef [LANES],
    output logic signed [DW-1:0] act_ofs  [LANES]
);

    logic                 armed_q;
    logic                 load_now;
    logic signed [CW-1:0] stg_coef [LANES];
    logic signed [DW-1:0] stg_ofs  [LANES];

    assign load_now = armed_q && in_valid;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= cfg_apply || (armed_q && !in_valid);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [1:0] COEF_SLOT = 2'(SLOT_COEF_I) + 2'(l);
        localparam logic [1:0] OFS_SLOT  = 2'(SLOT_OFS_I) + 2'(l);

        always_ff @(posedge clk) begin
            if (rst) begin
                stg_coef[l] <= '0;
                stg_ofs[l]  <= '0;
            end else if (cfg_wr) begin
                if (cfg_sel == COEF_SLOT) stg_coef[l] <= cfg_data[CW-1:0];
                if (cfg_sel == OFS_SLOT)  stg_ofs[l]  <= cfg_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                act_coef[l] <= '0;
                act_ofs[l]  <= '0;
            end else if (load_now) begin
                act_coef[l] <= stg_coef[l];
                act_ofs[l]  <= stg_ofs[l];
            end
        end
    end

endmodule

// File: rtl/iqc_phase_lane.sv
module iqc_phase_lane
    import iqc_pkg::*;
#(
    parameter int DW = SAMPLE_W_DEF,
    parameter int CW = COEF_W_DEF
) (
    input  logic signed [DW-1:0] own,
    input  logic signed [DW-1:0] other,
    input  logic signed [CW-1:0] coef,
    output logic signed [DW-1:0] sum
);

    localparam int PW = DW + CW;
    localparam int SH = CW + 2;
    localparam int WW = PW + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] term;
    logic signed [WW-1:0] wide;

    always_comb begin
        prod = PW'(other) * PW'(coef);
        term = prod >>> SH;
        wide = WW'(own) + WW'(term);
        sum  = DW'(clamp_to(longint'(wide), DW));
    end

endmodule

// File: rtl/iqc_offset_lane.sv
module iqc_offset_lane
    import iqc_pkg::*;
#(
    parameter int DW = SAMPLE_W_DEF
) (
    input  logic signed [DW-1:0] val,
    input  logic signed [DW-1:0] ofs,
    output logic signed [DW-1:0] res
);

    localparam int WW = DW + 1;

    logic signed [WW-1:0] wide;

    always_comb begin
        wide = WW'(val) + WW'(ofs);
        res  = DW'(clamp_to(longint'(wide), DW));
    end

endmodule

// File: rtl/iqc_corrector.sv
module iqc_corrector
    import iqc_pkg::*;
#(
    parameter int DW = SAMPLE_W_DEF,
    parameter int CW = COEF_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_sel,
    input  logic [DW-1:0]        cfg_data,
    input  logic                 cfg_apply,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);

    logic signed [CW-1:0] act_coef [LANES];
    logic signed [DW-1:0] act_ofs  [LANES];
    logic signed [DW-1:0] smp      [LANES];
    logic signed [DW-1:0] ph_sum   [LANES];
    logic signed [DW-1:0] s1_val   [LANES];
    logic signed [DW-1:0] s1_ofs   [LANES];
    logic signed [DW-1:0] fin      [LANES];
    logic signed [DW-1:0] s2_val   [LANES];
    logic                 s1_v;
    logic                 s2_v;

    logic signed [CW-1:0] act_ci;
    logic signed [CW-1:0] act_cq;
    logic signed [DW-1:0] act_oi;
    logic signed [DW-1:0] act_oq;

    assign smp[0] = in_i;
    assign smp[1] = in_q;
    assign act_ci = act_coef[0];
    assign act_cq = act_coef[1];
    assign act_oi = act_ofs[0];
    assign act_oq = act_ofs[1];

    iqc_regbank #(.DW(DW), .CW(CW)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .cfg_apply (cfg_apply),
        .act_coef  (act_coef),
        .act_ofs   (act_ofs)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        iqc_phase_lane #(.DW(DW), .CW(CW)) i_phase (
            .own   (smp[l]),
            .other (smp[LANES-1-l]),
            .coef  (act_coef[l]),
            .sum   (ph_sum[l])
        );

        // Stage 1: clipped phase sum plus the offset snapshot of the same bank.
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_val[l] <= '0;
                s1_ofs[l] <= '0;
            end else if (in_valid) begin
                s1_val[l] <= ph_sum[l];
                s1_ofs[l] <= act_ofs[l];
            end
        end

        iqc_offset_lane #(.DW(DW)) i_ofs (
            .val (s1_val[l]),
            .ofs (s1_ofs[l]),
            .res (fin[l])
        );

        // Stage 2: output register, held while no pair arrives.
        always_ff @(posedge clk) begin
            if (rst)       s2_val[l] <= '0;
            else if (s1_v) s2_val[l] <= fin[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
        end else begin
            s1_v <= in_valid;
            s2_v <= s1_v;
        end
    end

    assign out_valid = s2_v;
    assign out_i     = s2_val[0];
    assign out_q     = s2_val[1];

endmodule

// File: rtl/iqc_checker.sv
module iqc_checker #(
    parameter int DW = 16,
    parameter int CW = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_i,
    input logic signed [DW-1:0] in_q,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_i,
    input logic signed [DW-1:0] out_q,
    input logic signed [CW-1:0] act_ci,
    input logic signed [CW-1:0] act_cq,
    input logic signed [DW-1:0] act_oi,
    input logic signed [DW-1:0] act_oq
);

    logic [1:0] warm;
    logic       bank_zero;

    always_ff @(posedge clk) begin
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    assign bank_zero = (act_ci == '0) && (act_cq == '0) &&
                       (act_oi == '0) && (act_oq == '0);

    a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    a_r4_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0 && !out_valid) |-> ($stable(out_i) && $stable(out_q)));

    a_r7_bank_moves_on_sample: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0 && !$past(in_valid)) |->
            ($stable(act_ci) && $stable(act_cq) && $stable(act_oi) && $stable(act_oq)));

    a_r1_zero_bank_passthrough: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && $past(in_valid, 2) && $past(bank_zero, 2)) |->
            (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));

endmodule

bind iqc_corrector iqc_checker #(.DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .act_ci    (act_ci),
    .act_cq    (act_cq),
    .act_oi    (act_oi),
    .act_oq    (act_oq)
);

// File: tb/test_iqc_corrector.sv
`timescale 1ns/1ps
module test_iqc_corrector;

    localparam int DW = 16;
    localparam int CW = 12;
    localparam int MAXV = 32767;
    localparam int MINV = -32768;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic                 cfg_wr = 1'b0;
    logic [1:0]           cfg_sel = '0;
    logic [DW-1:0]        cfg_data = '0;
    logic                 cfg_apply = 1'b0;
    logic                 out_valid;
    logic signed [DW-1:0] out_i;
    logic signed [DW-1:0] out_q;

    int    checks = 0;
    int    errors = 0;
    string tag = "R8";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    iqc_corrector #(.DW(DW), .CW(CW)) i_iqc_corrector (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .cfg_apply(cfg_apply), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // Reference model: staging, working bank, arm flag, two-deep delay line.
    int stg [4];
    int act [4];
    bit armed;
    bit pv1, pv2;
    int pi1, pq1, pi2, pq2;

    function automatic int clip(input longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return int'(v);
    endfunction

    function automatic int coef_of(input int raw);
        int c;
        c = raw & ((1 << CW) - 1);
        if (c >= (1 << (CW - 1))) c = c - (1 << CW);
        return c;
    endfunction

    function automatic int ofs_of(input int raw);
        int o;
        o = raw & 32'hFFFF;
        if (o >= 32768) o = o - 65536;
        return o;
    endfunction

    function automatic int lane_out(input int own, input int oth, input int c, input int o);
        longint t;
        int     s;
        t = (longint'(oth) * c) >>> (CW + 2);
        s = clip(longint'(own) + t);
        return clip(longint'(s) + o);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) begin stg[k] = 0; act[k] = 0; end
            armed = 0; pv1 = 0; pv2 = 0; pi1 = 0; pq1 = 0; pi2 = 0; pq2 = 0;
        end else begin
            pv2 = pv1;
            if (pv1) begin pi2 = pi1; pq2 = pq1; end
            pv1 = in_valid;
            if (in_valid) begin
                pi1 = lane_out(int'(in_i), int'(in_q), coef_of(act[0]), ofs_of(act[2]));
                pq1 = lane_out(int'(in_q), int'(in_i), coef_of(act[1]), ofs_of(act[3]));
                if (armed)
                    for (int k = 0; k < 4; k++) act[k] = stg[k];
            end
            armed = cfg_apply || (armed && !in_valid);
            if (cfg_wr) stg[cfg_sel] = int'(cfg_data);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (out_valid !== pv2) begin
                errors++;
                $display("FAIL R4 out_valid actual %0d expected %0d", out_valid, pv2);
            end
            checks++;
            if (int'(out_i) != pi2 || int'(out_q) != pq2) begin
                errors++;
                $display("FAIL %s out actual %0d/%0d expected %0d/%0d",
                         tag, out_i, out_q, pi2, pq2);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        in_valid = 0; cfg_wr = 0; cfg_apply = 0;
    endtask

    task automatic pair(input int i, input int q);
        @(negedge clk);
        in_valid = 1; in_i = DW'(i); in_q = DW'(q); cfg_wr = 0; cfg_apply = 0;
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        in_valid = 0; cfg_wr = 1; cfg_sel = 2'(sel); cfg_data = DW'(data); cfg_apply = 0;
    endtask

    task automatic apply_now();
        @(negedge clk);
        in_valid = 0; cfg_wr = 0; cfg_apply = 1;
    endtask

    task automatic rand_pairs(input int n);
        for (int k = 0; k < n; k++) begin
            if (($urandom % 4) == 0) idle();
            else pair(int'($signed(16'($urandom))), int'($signed(16'($urandom))));
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R8: reset state
        checks++;
        if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
            errors++;
            $display("FAIL R8 reset actual %0d %0d %0d expected 0 0 0", out_valid, out_i, out_q);
        end
        tag = "R8";
        rand_pairs(40);

        // R1 R6: program coefficients, nothing moves before apply
        tag = "R6";
        wr(0, 700); wr(1, -1500); wr(2, 300); wr(3, -450);
        rand_pairs(20);
        tag = "R1";
        apply_now();
        repeat (3) idle();
        rand_pairs(80);

        // R5: long gaps between pairs
        tag = "R5";
        for (int k = 0; k < 10; k++) begin
            pair(1000 * k - 4000, 2500 - 700 * k);
            repeat (k % 4 + 1) idle();
        end

        // R2: phase clip, then offset pulls back inside
        tag = "R2";
        wr(0, 2047); wr(1, -2048); wr(2, -1000); wr(3, 1000);
        apply_now(); pair(0, 0);
        pair(MAXV, MAXV); pair(MINV, MAXV); pair(MAXV, MINV); pair(MINV, MINV);
        pair(30000, 32000); idle(); idle();

        // R3: offsets at both ends of the range
        tag = "R3";
        wr(0, 0); wr(1, 0); wr(2, MAXV); wr(3, MINV);
        apply_now(); pair(0, 0);
        pair(5, -5); pair(-20000, 20000); pair(MINV, MAXV); idle(); idle();
        wr(2, MINV); wr(3, MAXV); apply_now(); pair(1, 1);
        pair(100, -100); pair(MAXV, MINV); idle(); idle();

        // R7: arm while idle, then a sample meets the load edge with a fresh write
        tag = "R7";
        wr(2, 10); wr(3, 20); apply_now();
        repeat (4) idle();
        @(negedge clk);
        in_valid = 1; in_i = 16'sd111; in_q = 16'sd222;
        cfg_wr = 1; cfg_sel = 2'd2; cfg_data = 16'd555; cfg_apply = 0;
        pair(111, 222); pair(-7, 9);
        apply_now(); pair(0, 0); pair(111, 222);
        // apply and sample on one edge: loads at the next sample
        @(negedge clk);
        in_valid = 1; in_i = 16'sd50; in_q = 16'sd60; cfg_wr = 0; cfg_apply = 1;
        wr(2, -77);
        pair(50, 60); pair(50, 60); idle(); idle();

        // R1 R4: coefficient extremes with random traffic
        tag = "R1";
        wr(0, -2048); wr(1, 2047); wr(2, 0); wr(3, 0);
        apply_now();
        rand_pairs(100);
        tag = "R4";
        rand_pairs(60);
        repeat (4) idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule